// File: doc/BRIEF.md
# Fetch-Deadlock-Safe Request/Reply Endpoint

This block is the buffering front end of one node's network interface in a machine of `P` nodes. Traffic is split into two classes that never share storage. Requests go through a request input queue and a request output queue. Replies and negative acknowledgements go through a reply input queue and a reply output queue. The block never pushes back on the network. Every arriving packet addressed to the node is taken in the cycle it is presented, so the network can always drain even while the node's own output is stalled.

The local agent issues requests through an issue port. No more than `K` of them may be in flight at once. Completions (replies or NACKs to those requests) leave through a completion port, and popping a completion frees its slot. Arriving requests go through a built-in turnaround handler that emits exactly one reply per stored request. The request input queue holds `K*(P-1)` entries, which is enough for every other node's full allowance. A request that still finds that queue full is answered with a NACK carrying the requester's ID and tag, so the requester can retry. Reply-class packets always win the output port over requests.

Packets are `2+2*IDW+TAGW` bits wide, where `IDW = clog2(P)`. From the most significant end the fields are kind (2 bits), source ID, destination ID and tag. The kind codes are 0 = empty, 1 = request, 2 = reply and 3 = NACK.

Top module: `fetch_safe_endpoint`

## Requirements
- R1: Right after reset `out_valid` and `cpl_valid` are 0 and `iss_ready` is 1.
- R2: `iss_ready` is 0 while `K` issued requests are outstanding, and an issue attempt in that state sends nothing.
- R3: A slot is freed when a completion is popped (`cpl_valid && cpl_ready`). Receiving the completion does not free it.
- R4: An accepted issue appears at `out_pkt` as kind 1, source `NODE_ID`, and the issued destination and tag. `out_valid` stays high until `out_ready`.
- R5: Each stored request yields exactly one reply of kind 2, with source `NODE_ID`, destination equal to the requester and the same tag. Replies leave in arrival order.
- R6: The request input queue stores `K*(P-1)` requests. A request that arrives while it is full, and while the reply output queue has room, produces a NACK of kind 3 with source `NODE_ID`, destination equal to the requester and the same tag. The NACK is queued behind the replies already waiting.
- R7: While any reply or NACK is waiting to leave, `out_pkt` shows it rather than a pending request.
- R8: Incoming replies and NACKs are taken while the output is blocked and are presented at `cpl_pkt` in arrival order.
- R9: A request that arrives while both the request input queue and the reply output queue are full is discarded and produces nothing.
- R10: Packets whose destination is not `NODE_ID`, and packets of kind 0, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Network packet present (always accepted) |
| in_pkt | input | PW | Network packet |
| out_valid | output | 1 | Outgoing packet available |
| out_pkt | output | PW | Outgoing packet |
| out_ready | input | 1 | Network takes the outgoing packet |
| iss_valid | input | 1 | Local agent issues a request |
| iss_dst | input | IDW | Destination node of the issued request |
| iss_tag | input | TAGW | Tag of the issued request |
| iss_ready | output | 1 | A request slot is free |
| cpl_valid | output | 1 | A reply or NACK is waiting for the local agent |
| cpl_pkt | output | PW | The waiting reply or NACK |
| cpl_ready | input | 1 | Local agent pops the completion |

## Verification
A slot-counter error shows up directly on `iss_ready`. It is visible one cycle after the issue or pop that was miscounted. Queue pointer or depth errors appear at `out_pkt` as a reordered, duplicated or missing reply, or as an early or missing NACK. Such errors surface only when the output is released and the queue is drained, so the bench fills both request-side queues with the output stalled and then compares the whole drained stream with a list it computes itself. A priority error shows as the pending request leaving ahead of queued replies.

// File: rtl/ep_pkg.sv
package ep_pkg;
   typedef enum logic [1:0] {
      PK_NONE = 2'd0,
      PK_REQ  = 2'd1,
      PK_RSP  = 2'd2,
      PK_NACK = 2'd3
   } pk_kind_e;
endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_q];

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            rd_q <= '0;
            wr_q <= '0;
         end
      end else begin : g_ring
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q <= '0;
               wr_q <= '0;
            end else begin
               if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
               if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/ep_slot_ctr.sv
module ep_slot_ctr #(
   parameter int K = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic avail
);
   localparam int CW = $clog2(K + 1);
   logic [CW-1:0] used_q;

   assign avail = (used_q < CW'(K));

   always_ff @(posedge clk) begin
      if (!rst_n) used_q <= '0;
      else begin
         case ({take && avail, give && (used_q != '0)})
            2'b10:   used_q <= used_q + 1'b1;
            2'b01:   used_q <= used_q - 1'b1;
            default: used_q <= used_q;
         endcase
      end
   end
endmodule

// File: rtl/ep_turnaround.sv
module ep_turnaround
   import ep_pkg::*;
#(
   parameter int       IDW     = 2,
   parameter int       TAGW    = 4,
   parameter int       NODE_ID = 0,
   parameter pk_kind_e KIND    = PK_RSP
) (
   input  logic [IDW-1:0]          req_src,
   input  logic [TAGW-1:0]         req_tag,
   output logic [2+2*IDW+TAGW-1:0] pkt
);
   assign pkt = {KIND, IDW'(NODE_ID), req_src, req_tag};
endmodule

// File: rtl/fetch_safe_endpoint.sv
module fetch_safe_endpoint
   import ep_pkg::*;
#(
   parameter int P       = 4,
   parameter int K       = 2,
   parameter int TAGW    = 4,
   parameter int NODE_ID = 0,
   parameter int IDW     = (P > 1) ? $clog2(P) : 1,
   parameter int PW      = 2 + 2*IDW + TAGW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [PW-1:0]   in_pkt,
   output logic            out_valid,
   output logic [PW-1:0]   out_pkt,
   input  logic            out_ready,
   input  logic            iss_valid,
   input  logic [IDW-1:0]  iss_dst,
   input  logic [TAGW-1:0] iss_tag,
   output logic            iss_ready,
   output logic            cpl_valid,
   output logic [PW-1:0]   cpl_pkt,
   input  logic            cpl_ready
);
   localparam int REQ_IN_D  = K * (P - 1);
   localparam int RSP_IN_D  = K;
   localparam int REQ_OUT_D = K;
   localparam int RSP_OUT_D = REQ_IN_D;

   generate
      if (P < 2)                      begin : g_bad_p  $error("P must be at least 2");        end
      if (K < 1)                      begin : g_bad_k  $error("K must be at least 1");        end
      if (NODE_ID >= P)               begin : g_bad_id $error("NODE_ID must be below P");     end
      if (PW != 2 + 2*IDW + TAGW)     begin : g_bad_pw $error("PW must match field widths");  end
   endgenerate

   pk_kind_e       in_kind, out_kind;
   logic [IDW-1:0] in_src, in_dst;
   logic           in_for_me;
   assign in_kind   = pk_kind_e'(in_pkt[PW-1 -: 2]);
   assign in_src    = in_pkt[PW-3 -: IDW];
   assign in_dst    = in_pkt[TAGW +: IDW];
   assign in_for_me = in_valid && (in_dst == IDW'(NODE_ID));

   logic req_in_full, req_in_empty, rsp_in_full, rsp_in_empty;
   logic req_out_full, req_out_empty, rsp_out_full, rsp_out_empty;
   logic [PW-1:0] req_in_head, req_out_head, rsp_out_head;
   logic [PW-1:0] reply_pkt, nack_pkt, iss_pkt;

   logic is_req, is_cmp, nack_push, hdl_go;
   assign is_req    = in_for_me && (in_kind == PK_REQ);
   assign is_cmp    = in_for_me && (in_kind == PK_RSP || in_kind == PK_NACK);
   assign nack_push = is_req && req_in_full && !rsp_out_full;
   assign hdl_go    = !req_in_empty && !rsp_out_full && !nack_push;

   ep_turnaround #(.IDW(IDW), .TAGW(TAGW), .NODE_ID(NODE_ID), .KIND(PK_RSP)) u_reply (
      .req_src (req_in_head[PW-3 -: IDW]),
      .req_tag (req_in_head[TAGW-1:0]),
      .pkt     (reply_pkt)
   );

   ep_turnaround #(.IDW(IDW), .TAGW(TAGW), .NODE_ID(NODE_ID), .KIND(PK_NACK)) u_nack (
      .req_src (in_src),
      .req_tag (in_pkt[TAGW-1:0]),
      .pkt     (nack_pkt)
   );

   ep_fifo #(.W(PW), .DEPTH(REQ_IN_D)) u_req_in (
      .clk, .rst_n,
      .push (is_req), .push_data (in_pkt), .pop (hdl_go),
      .head (req_in_head), .full (req_in_full), .empty (req_in_empty)
   );

   ep_fifo #(.W(PW), .DEPTH(RSP_OUT_D)) u_rsp_out (
      .clk, .rst_n,
      .push (nack_push || hdl_go), .push_data (nack_push ? nack_pkt : reply_pkt),
      .pop (out_ready),
      .head (rsp_out_head), .full (rsp_out_full), .empty (rsp_out_empty)
   );

   ep_fifo #(.W(PW), .DEPTH(RSP_IN_D)) u_rsp_in (
      .clk, .rst_n,
      .push (is_cmp), .push_data (in_pkt), .pop (cpl_ready),
      .head (cpl_pkt), .full (rsp_in_full), .empty (rsp_in_empty)
   );

   assign iss_pkt = {PK_REQ, IDW'(NODE_ID), iss_dst, iss_tag};

   ep_fifo #(.W(PW), .DEPTH(REQ_OUT_D)) u_req_out (
      .clk, .rst_n,
      .push (iss_valid && iss_ready), .push_data (iss_pkt),
      .pop (out_ready && rsp_out_empty),
      .head (req_out_head), .full (req_out_full), .empty (req_out_empty)
   );

   ep_slot_ctr #(.K(K)) u_slots (
      .clk, .rst_n,
      .take  (iss_valid && !req_out_full),
      .give  (cpl_valid && cpl_ready),
      .avail (iss_ready)
   );

   assign cpl_valid = !rsp_in_empty;
   assign out_valid = !rsp_out_empty || !req_out_empty;
   assign out_pkt   = rsp_out_empty ? req_out_head : rsp_out_head;
   assign out_kind  = pk_kind_e'(out_pkt[PW-1 -: 2]);
endmodule

// File: rtl/ep_checker.sv
module ep_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       iss_valid,
   input logic       iss_ready,
   input logic       cpl_valid,
   input logic       cpl_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [1:0] out_kind,
   input logic [1:0] in_kind,
   input logic       in_for_me,
   input logic       req_in_full,
   input logic       rsp_in_full,
   input logic       rsp_out_empty,
   input logic       rsp_out_full
);
   a_r2_stay_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_ready && !(cpl_valid && cpl_ready)) |=> !iss_ready);

   a_r3_slot_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_ready && !iss_valid) |=> iss_ready);

   a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid);

   a_r6_nack_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      (in_for_me && in_kind == 2'd1 && req_in_full && !rsp_out_full) |=> out_valid);

   a_r7_reply_first: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_out_empty |-> (out_valid && out_kind != 2'd1));

   a_r8_reply_room: assert property (@(posedge clk) disable iff (!rst_n)
      (in_for_me && in_kind[1]) |-> !rsp_in_full);
endmodule

bind fetch_safe_endpoint ep_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .iss_valid     (iss_valid),
   .iss_ready     (iss_ready),
   .cpl_valid     (cpl_valid),
   .cpl_ready     (cpl_ready),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_kind      (out_kind),
   .in_kind       (in_kind),
   .in_for_me     (in_for_me),
   .req_in_full   (req_in_full),
   .rsp_in_full   (rsp_in_full),
   .rsp_out_empty (rsp_out_empty),
   .rsp_out_full  (rsp_out_full)
);

// File: tb/fetch_safe_endpoint_tb_top.sv
`timescale 1ns/1ps
module fetch_safe_endpoint_tb_top;
   localparam int P = 4, K = 2, TAGW = 4, IDW = 2, PW = 2 + 2*IDW + TAGW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, out_ready = 1'b0, iss_valid = 1'b0, cpl_ready = 1'b0;
   logic [PW-1:0]   in_pkt = '0;
   logic [IDW-1:0]  iss_dst = '0;
   logic [TAGW-1:0] iss_tag = '0;
   logic            out_valid, iss_ready, cpl_valid;
   logic [PW-1:0]   out_pkt, cpl_pkt;

   int checks = 0, errors = 0;
   logic [PW-1:0] got [32];
   int gotn;

   always #2.5 clk = ~clk;

   fetch_safe_endpoint #(.P(P), .K(K), .TAGW(TAGW), .NODE_ID(0)) dut_i (
      .clk, .rst_n, .in_valid, .in_pkt, .out_valid, .out_pkt, .out_ready,
      .iss_valid, .iss_dst, .iss_tag, .iss_ready, .cpl_valid, .cpl_pkt, .cpl_ready
   );

   function automatic logic [PW-1:0] mk(input int kind, input int src, input int dst, input int tag);
      return {2'(kind), IDW'(src), IDW'(dst), TAGW'(tag)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic inj(input logic [PW-1:0] p);
      in_valid = 1'b1; in_pkt = p;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic collect(input int cycles);
      gotn = 0;
      out_ready = 1'b1;
      for (int c = 0; c < cycles; c++) begin
         if (out_valid) begin got[gotn] = out_pkt; gotn++; end
         @(negedge clk);
      end
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [PW-1:0] exp_list [13];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
      chk(cpl_valid == 1'b0, "R1 cpl_valid", 32'(cpl_valid), 0);
      chk(iss_ready == 1'b1, "R1 iss_ready", 32'(iss_ready), 1);

      // R2 / R4: fill the K slots with output blocked
      iss_valid = 1'b1; iss_dst = 2'd1; iss_tag = 4'd3;
      @(negedge clk);
      iss_dst = 2'd2; iss_tag = 4'd5;
      @(negedge clk);
      chk(iss_ready == 1'b0, "R2 ready low at limit", 32'(iss_ready), 0);
      iss_dst = 2'd3; iss_tag = 4'd7;
      @(negedge clk);
      iss_valid = 1'b0;
      chk(out_valid == 1'b1, "R4 valid held", 32'(out_valid), 1);
      collect(6);
      chk(gotn == 2, "R2 only K requests sent", 32'(gotn), 2);
      chk(got[0] == mk(1, 0, 1, 3), "R4 first request", 32'(got[0]), 32'(mk(1, 0, 1, 3)));
      chk(got[1] == mk(1, 0, 2, 5), "R4 second request", 32'(got[1]), 32'(mk(1, 0, 2, 5)));

      // R3 / R8 completions
      inj(mk(2, 1, 0, 3));
      chk(cpl_valid && cpl_pkt == mk(2, 1, 0, 3), "R8 reply delivered", 32'(cpl_pkt), 32'(mk(2, 1, 0, 3)));
      inj(mk(3, 2, 0, 5));
      chk(iss_ready == 1'b0, "R3 no release before pop", 32'(iss_ready), 0);
      cpl_ready = 1'b1;
      @(negedge clk);
      chk(iss_ready == 1'b1, "R3 release on pop", 32'(iss_ready), 1);
      chk(cpl_pkt == mk(3, 2, 0, 5), "R8 completion order", 32'(cpl_pkt), 32'(mk(3, 2, 0, 5)));
      @(negedge clk);
      cpl_ready = 1'b0;
      chk(cpl_valid == 1'b0, "R8 completions drained", 32'(cpl_valid), 0);

      // R10 ignored packets
      inj(mk(1, 2, 1, 15));
      inj(mk(0, 1, 0, 14));
      @(negedge clk);
      chk(out_valid == 1'b0 && cpl_valid == 1'b0, "R10 foreign and empty ignored", 32'({out_valid, cpl_valid}), 0);

      // R5 first batch of requests, output blocked
      for (int i = 0; i < 6; i++) begin
         in_valid = 1'b1; in_pkt = mk(1, 1 + i % 3, 0, i);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_pkt == mk(2, 0, 1, 0), "R5 first reply", 32'(out_pkt), 32'(mk(2, 0, 1, 0)));

      // local request queued behind replies; completion accepted while blocked
      iss_valid = 1'b1; iss_dst = 2'd3; iss_tag = 4'd9;
      @(negedge clk);
      iss_valid = 1'b0;
      inj(mk(2, 3, 0, 9));
      chk(cpl_valid && cpl_pkt == mk(2, 3, 0, 9), "R8 accepted while output blocked", 32'(cpl_pkt), 32'(mk(2, 3, 0, 9)));
      cpl_ready = 1'b1;
      @(negedge clk);
      cpl_ready = 1'b0;
      chk(out_pkt == mk(2, 0, 1, 0), "R7 reply shown over request", 32'(out_pkt), 32'(mk(2, 0, 1, 0)));

      // second batch fills request input, then one dropped (R9)
      for (int i = 6; i < 13; i++) begin
         in_valid = 1'b1; in_pkt = mk(1, 1 + i % 3, 0, i);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (2) @(negedge clk);

      // free one reply slot, then a request must be NACKed (R6)
      out_ready = 1'b1;
      chk(out_pkt == mk(2, 0, 1, 0), "R5 head before pop", 32'(out_pkt), 32'(mk(2, 0, 1, 0)));
      @(negedge clk);
      out_ready = 1'b0;
      inj(mk(1, 2, 0, 13));
      repeat (2) @(negedge clk);

      for (int i = 1; i < 6; i++) exp_list[i-1] = mk(2, 0, 1 + i % 3, i);
      exp_list[5] = mk(3, 0, 2, 13);
      for (int i = 6; i < 12; i++) exp_list[i] = mk(2, 0, 1 + i % 3, i);
      exp_list[12] = mk(1, 0, 3, 9);
      collect(30);
      chk(gotn == 13, "R9 dropped request produced nothing", 32'(gotn), 13);
      for (int i = 0; i < 13; i++) begin
         if (i < gotn)
            chk(got[i] == exp_list[i],
                (i == 5) ? "R6 nack" : (i == 12) ? "R7 request last" : "R5 reply order",
                32'(got[i]), 32'(exp_list[i]));
      end
      chk(out_valid == 1'b0, "R5 no extra packets", 32'(out_valid), 0);
      chk(iss_ready == 1'b1, "R3 slots free at end", 32'(iss_ready), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule